// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between a set of divided system clocks and the pins that carry them. Three active-low power-management requests (CPU stop, PCI stop and power-down) decide which clocks reach their outputs. Each request arrives asynchronously. It is first synchronized to the free-running PCI clock. The resulting gate enables are then retimed on the falling edge of each clock they control. A gated output therefore only switches on or off during the low phase of its own clock, and never produces a shortened pulse.

CPU stop parks the CPU clock and the 66 MHz clock. PCI stop parks the PCI bus clock. The free-running copy of the PCI clock is exempt from PCI stop. Power-down parks every output and clears the oscillator/VCO enable flag. When power-down is released, the enable flag rises first. The clocks stay parked until a settling counter, measured in free-running PCI clock cycles, has expired. Reset is treated the same way as a release from power-down.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While CPU stop is low, `gcpu` and `g66` stay low and produce no rising edges. `ghalf`, `gapic`, `gref`, `gusb`, `gpci` and `gpci_free` keep toggling.
- R2: While PCI stop is low, `gpci` stays low. `gpci_free` and all the other outputs keep toggling, unless CPU stop parks them as stated in R1.
- R3: While power-down is low, all eight gated outputs stay low and `osc_en` is low, whatever the levels of the two stop requests.
- R4: After power-down rises, or after reset is released, `osc_en` is high by the third rising edge of `clk_pci`. Every gated output stays low until SETTLE_CYCLES further `clk_pci` cycles have elapsed. After that, every output that no stop request parks toggles again.
- R5: A change on CPU stop or PCI stop passes through two `clk_pci` rising edges of synchronization. The affected outputs keep their old behaviour up to the second rising edge after the change, and show the new behaviour from the third rising edge onward. This holds both when stopping and when restarting.
- R6: The gate on each output changes only while that output's source clock is low. Every high pulse on a gated output lasts the full high phase of its source clock.
- R7: While `rst_n` is low, all gated outputs and `osc_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pci | input | 1 | Free-running PCI clock; synchronizer and settle-timer domain |
| rst_n | input | 1 | Synchronous active-low reset, in the `clk_pci` domain |
| clk_cpu | input | 1 | Ungated CPU clock |
| clk_half | input | 1 | Ungated half-rate CPU clock |
| clk_66 | input | 1 | Ungated 66 MHz clock |
| clk_apic | input | 1 | Ungated interrupt-controller clock |
| clk_ref | input | 1 | Ungated reference clock |
| clk_usb | input | 1 | Ungated 48 MHz clock |
| cpu_stop_n | input | 1 | Asynchronous CPU-stop request, active low |
| pci_stop_n | input | 1 | Asynchronous PCI-stop request, active low |
| pwr_dn_n | input | 1 | Asynchronous power-down request, active low |
| gcpu | output | 1 | Gated CPU clock |
| ghalf | output | 1 | Gated half-rate CPU clock |
| g66 | output | 1 | Gated 66 MHz clock |
| gapic | output | 1 | Gated interrupt-controller clock |
| gref | output | 1 | Gated reference clock |
| gusb | output | 1 | Gated 48 MHz clock |
| gpci | output | 1 | Gated PCI bus clock |
| gpci_free | output | 1 | Free-running PCI clock, parked only by power-down |
| osc_en | output | 1 | Oscillator/VCO enable, low during power-down |

## Verification
Some properties are checked on every `clk_pci` cycle:
- a power-down request clears the settle timer;
- the timer can only complete after a cycle with no power-down request;
- the retimed enables of the PCI gate and of the free-running PCI gate always match the run decisions for their groups.

The bench scenarios cover behaviour that spans many clock domains or long windows:
- which outputs toggle under each combination of requests;
- the exact edge on which a stop or restart takes effect;
- the length of the settling interval after power-down or reset;
- the absence of shortened high pulses on every gated output.

// File: rtl/clkstop_pkg.sv
// Shared definitions for the clock stop controller.
// Assumes gate index order: 0 cpu, 1 66, 2 half, 3 apic, 4 ref, 5 usb, 6 pci, 7 pci_free.
package clkstop_pkg;

    localparam int NUM_GATES = 8;

    typedef enum logic [1:0] {
        GRP_CPU = 2'd0,   // parked by CPU stop and by power-down
        GRP_PCI = 2'd1,   // parked by PCI stop and by power-down
        GRP_ALL = 2'd2    // parked only by power-down
    } gate_grp_e;

    // Maps a gate index to the request group that controls it.
    function automatic gate_grp_e gate_group(input int idx);
        if (idx <= 1) return GRP_CPU;
        if (idx == 6) return GRP_PCI;
        return GRP_ALL;
    endfunction

endpackage

// File: rtl/req_sync.sv
// Multi-stage synchronizer for a vector of asynchronous request bits.
// Assumes every bit is an independent level. Reset loads RST_VAL into all stages.
module req_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] pipe [STAGES];

    // Shift the request levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= async_i;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/settle_timer.sv
// Counts SETTLE_CYCLES clock cycles after power-down is released, then raises done_o.
// Assumes pd_i is already synchronous to clk. Any power-down cycle restarts the count.
module settle_timer #(
    parameter int SETTLE_CYCLES = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Clear on power-down, otherwise count up and latch completion.
    always_ff @(posedge clk) begin
        if (!rst_n || pd_i) begin
            cnt    <= '0;
            done_o <= 1'b0;
        end else if (!done_o) begin
            if (cnt == CNT_W'(SETTLE_CYCLES - 1)) done_o <= 1'b1;
            else                                  cnt    <= cnt + 1'b1;
        end
    end

    // R4: a power-down request always withdraws the settled state.
    p_pd_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pd_i |=> !done_o);

    // R4: completion can only follow a cycle free of power-down.
    p_done_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(!pd_i));
endmodule

// File: rtl/clk_gate_cell.sv
// Glitch-free gate for one clock: the enable is retimed on the clock's falling edge.
// Assumes en_i changes at most once per clk_i period. rst_n is held for several clk_i periods.
module clk_gate_cell (
    input  logic clk_i,
    input  logic rst_n,
    input  logic en_i,
    output logic gclk_o
);
    logic en_q;

    // Capture the enable only while the clock is low.
    always_ff @(negedge clk_i) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_i;
    end

    assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/clk_stop_ctrl.sv
// Top of the clock stop controller.
// Synchronizes the three requests to clk_pci, runs the settle timer,
// and drives one glitch-free gate per output clock.
// Assumes rst_n is synchronous to clk_pci and long enough to reach every gate domain.
module clk_stop_ctrl
    import clkstop_pkg::*;
#(
    parameter int SETTLE_CYCLES = 300000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk_pci,
    input  logic rst_n,
    input  logic clk_cpu,
    input  logic clk_half,
    input  logic clk_66,
    input  logic clk_apic,
    input  logic clk_ref,
    input  logic clk_usb,
    input  logic cpu_stop_n,
    input  logic pci_stop_n,
    input  logic pwr_dn_n,
    output logic gcpu,
    output logic ghalf,
    output logic g66,
    output logic gapic,
    output logic gref,
    output logic gusb,
    output logic gpci,
    output logic gpci_free,
    output logic osc_en
);
    localparam int NREQ = 3;

    logic [NREQ-1:0]      req_s;     // [0] cpu stop, [1] pci stop, [2] power-down
    logic                 settled;
    logic                 run_all, run_cpu, run_pci;
    logic [NUM_GATES-1:0] clk_vec, gclk_vec;

    req_sync #(.WIDTH(NREQ), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk    (clk_pci),
        .rst_n  (rst_n),
        .async_i({~pwr_dn_n, ~pci_stop_n, ~cpu_stop_n}),
        .sync_o (req_s)
    );

    settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk   (clk_pci),
        .rst_n (rst_n),
        .pd_i  (req_s[2]),
        .done_o(settled)
    );

    // Run decisions per request group.
    always_comb begin
        run_all = ~req_s[2] & settled;
        run_cpu = run_all & ~req_s[0];
        run_pci = run_all & ~req_s[1];
    end

    assign osc_en  = ~req_s[2];
    assign clk_vec = {clk_pci, clk_pci, clk_usb, clk_ref, clk_apic, clk_half, clk_66, clk_cpu};

    for (genvar gi = 0; gi < NUM_GATES; gi++) begin : g_gate
        localparam gate_grp_e GRP = gate_group(gi);
        logic en_sel;
        if (GRP == GRP_CPU) begin : g_cpu
            assign en_sel = run_cpu;
        end else if (GRP == GRP_PCI) begin : g_pci
            assign en_sel = run_pci;
        end else begin : g_all
            assign en_sel = run_all;
        end
        clk_gate_cell u_cell (
            .clk_i (clk_vec[gi]),
            .rst_n (rst_n),
            .en_i  (en_sel),
            .gclk_o(gclk_vec[gi])
        );
    end

    assign {gpci_free, gpci, gusb, gref, gapic, ghalf, g66, gcpu} = gclk_vec;

    // R2: the retimed PCI gate enable tracks the PCI run decision.
    p_pci_gate_r2: assert property (@(posedge clk_pci) disable iff (!rst_n)
        g_gate[6].u_cell.en_q == run_pci);

    // R3: the free-running PCI gate follows only the power-down/settle decision.
    p_free_gate_r3: assert property (@(posedge clk_pci) disable iff (!rst_n)
        g_gate[7].u_cell.en_q == run_all);
endmodule

// File: tb/tb_clk_stop_ctrl.sv
`timescale 1ns/100ps
module tb_clk_stop_ctrl;
    localparam int SETTLE = 50;

    logic clk_pci = 0, clk_cpu = 0, clk_half = 0, clk_66 = 0;
    logic clk_apic = 0, clk_ref = 0, clk_usb = 0;
    logic rst_n = 0, cpu_stop_n = 1, pci_stop_n = 1, pwr_dn_n = 1;
    logic gcpu, ghalf, g66, gapic, gref, gusb, gpci, gpci_free, osc_en;
    logic [7:0] g;

    int  checks = 0, fails = 0;
    int  cnt  [8];
    int  runts[8];
    bit  counting = 0, mon_on = 0, finished = 0;

    // Gate half periods, index order 0 cpu, 1 66, 2 half, 3 apic, 4 ref, 5 usb, 6 pci, 7 pci_free.
    localparam real HALFP [8] = '{2.5, 5.0, 5.0, 10.0, 7.0, 3.0, 5.0, 5.0};

    // Vectors: {pwr_dn_n, cpu_stop_n, pci_stop_n, osc_en, running mask[7:0]}.
    localparam logic [11:0] VEC [6] = '{
        {1'b1, 1'b1, 1'b1, 1'b1, 8'hFF},
        {1'b1, 1'b0, 1'b1, 1'b1, 8'hFC},
        {1'b1, 1'b1, 1'b0, 1'b1, 8'hBF},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'hBC},
        {1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h00}
    };

    clk_stop_ctrl #(.SETTLE_CYCLES(SETTLE)) dut (
        .clk_pci(clk_pci), .rst_n(rst_n), .clk_cpu(clk_cpu), .clk_half(clk_half),
        .clk_66(clk_66), .clk_apic(clk_apic), .clk_ref(clk_ref), .clk_usb(clk_usb),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
        .gcpu(gcpu), .ghalf(ghalf), .g66(g66), .gapic(gapic), .gref(gref),
        .gusb(gusb), .gpci(gpci), .gpci_free(gpci_free), .osc_en(osc_en)
    );

    assign g = {gpci_free, gpci, gusb, gref, gapic, ghalf, g66, gcpu};

    initial forever #5 clk_pci = ~clk_pci;
    initial begin #0.7; forever #2.5 clk_cpu  = ~clk_cpu;  end
    initial begin #1.3; forever #5   clk_half = ~clk_half; end
    initial begin #2.1; forever #5   clk_66   = ~clk_66;   end
    initial begin #0.9; forever #10  clk_apic = ~clk_apic; end
    initial begin #1.7; forever #7   clk_ref  = ~clk_ref;  end
    initial begin #0.4; forever #3   clk_usb  = ~clk_usb;  end

    for (genvar i = 0; i < 8; i++) begin : g_mon
        realtime t_up = 0;
        bit      armed = 0;
        initial begin cnt[i] = 0; runts[i] = 0; end
        always @(posedge g[i]) begin
            t_up  = $realtime;
            armed = mon_on;
            if (counting) cnt[i] = cnt[i] + 1;
        end
        always @(negedge g[i]) begin
            if (armed && ($realtime - t_up < HALFP[i] - 0.05)) runts[i] = runts[i] + 1;
            armed = 0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk_pci);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Count rising edges of every output over n clk_pci cycles; return a running mask.
    task automatic window(input int n, output logic [7:0] run);
        for (int i = 0; i < 8; i++) cnt[i] = 0;
        counting = 1;
        tick(n);
        counting = 0;
        for (int i = 0; i < 8; i++) run[i] = (cnt[i] > 0) || g[i];
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] run;
        int total_runts;
        tick(10);
        // R7: reset parks everything.
        check(g == 8'h00, "R7", "outputs in reset", g, 0);
        check(osc_en == 1'b0, "R7", "osc_en in reset", osc_en, 0);
        rst_n = 1;
        mon_on = 1;
        tick(3);
        check(osc_en == 1'b1, "R4", "osc_en after reset release", osc_en, 1);
        window(SETTLE - 10, run);
        check(run == 8'h00, "R4", "outputs during post-reset settling", run, 0);

        // Table walk: R1, R2, R3 and R4 settle completion.
        for (int v = 0; v < 6; v++) begin
            pwr_dn_n   = VEC[v][11];
            cpu_stop_n = VEC[v][10];
            pci_stop_n = VEC[v][9];
            tick(SETTLE + 10);
            check(osc_en == VEC[v][8], "R3", $sformatf("osc_en vector %0d", v), osc_en, VEC[v][8]);
            window(20, run);
            check(run == VEC[v][7:0], "R1/R2/R3", $sformatf("running mask vector %0d", v),
                  run, VEC[v][7:0]);
        end

        // Back to full run.
        pwr_dn_n = 1; cpu_stop_n = 1; pci_stop_n = 1;
        tick(SETTLE + 10);

        // R5: CPU stop takes effect after the second edge, not before.
        cpu_stop_n = 0;
        tick(1);
        window(1, run);
        check(run[0], "R5", "cpu still running before sync completes", run[0], 1);
        tick(1);
        window(10, run);
        check(run[1:0] == 2'b00, "R5", "cpu/66 stopped from third edge", run[1:0], 0);
        // R5: restart latency.
        cpu_stop_n = 1;
        tick(1);
        window(1, run);
        check(run[0] == 1'b0, "R5", "cpu still parked before sync completes", run[0], 0);
        tick(1);
        window(2, run);
        check(run[1:0] == 2'b11, "R5", "cpu/66 running from third edge", run[1:0], 3);

        // R5: PCI stop latency, free-running copy unaffected (R2).
        pci_stop_n = 0;
        tick(1);
        window(1, run);
        check(run[6], "R5", "pci still running before sync completes", run[6], 1);
        tick(1);
        window(10, run);
        check(run[7:6] == 2'b10, "R2", "pci parked, pci_free running", run[7:6], 2);
        pci_stop_n = 1;
        tick(3);
        window(2, run);
        check(run[6], "R5", "pci restarted from third edge", run[6], 1);

        // R3: power-down entry parks all outputs from the third edge.
        pwr_dn_n = 0;
        tick(3);
        check(osc_en == 1'b0, "R3", "osc_en off after power-down", osc_en, 0);
        window(10, run);
        check(run == 8'h00, "R3", "all outputs parked in power-down", run, 0);

        // R4: release: osc_en first, clocks only after settling.
        pwr_dn_n = 1;
        tick(3);
        check(osc_en == 1'b1, "R4", "osc_en raised on release", osc_en, 1);
        window(20, run);
        check(run == 8'h00, "R4", "outputs parked while settling", run, 0);
        tick(SETTLE);
        window(10, run);
        check(run == 8'hFF, "R4", "all outputs running after settling", run, 8'hFF);

        // R6: no shortened high pulse seen on any output during the run.
        total_runts = 0;
        for (int i = 0; i < 8; i++) total_runts += runts[i];
        check(total_runts == 0, "R6", "shortened high pulses", total_runts, 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule